// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit turns the operand fields of a processor's memory instructions into a memory request. It accepts three addressing forms. The first is a plain register pointer. The second is a base register plus a scaled 5-bit constant. The third is a base register plus an index register. The base register is one of two dedicated pointer registers, called R14 and R15 here. The unit forces the address to the natural alignment of the access. It then decides whether the address lands in the 8 KB local work memory or on the external bus, and it shapes halfword store data for the chosen path.

The address arithmetic is combinational. One register stage, loaded only when a request is presented, holds the result together with a valid bit, so the request appears at the outputs on the clock edge after it is presented. The local memory itself, bus arbitration and the instruction pipeline are outside this unit.

A parameter can switch off alignment masking for stores only. This lets the unaligned store addresses of an unmasked variant be compared against the masked ones.

Top module: `lsu_addr_gen`

## Requirements
- R1: In base-plus-constant mode, a constant field value of 1 to 31 gives a byte offset of four times that value, and a field value of 0 gives a byte offset of 128 (32 longwords).
- R2: In base-plus-constant mode (`req_mode` = 1), the base is R14 when `req_base_sel` = 0 and R15 when it is 1. The base's two low bits are cleared before the offset is added, and the access is always a longword.
- R3: In base-plus-index mode (`req_mode` = 2), the address is the sum of the selected base and `req_index` with its two low bits cleared, and the access is always a longword.
- R4: In pointer mode (`req_mode` = 0, and the reserved code 3 behaves the same way), the address is `req_index` with bits 1:0 cleared for a longword (`req_word` = 0) and only bit 0 cleared for a halfword (`req_word` = 1). `req_word` has no effect in the other modes, and `out_word` reports the size actually used.
- R5: `out_local` is 1 exactly when `out_addr` lies in the range from LOCAL_BASE to LOCAL_BASE + 0x1FFF inclusive.
- R6: A halfword store to local memory is issued as a longword write (`out_long` = 1). A halfword store outside it is issued as a halfword access (`out_long` = 0). For any halfword store, `out_wdata` is the low 16 bits of `req_wdata` zero-extended. For a longword store, `out_wdata` equals `req_wdata`.
- R7: A halfword load from local memory is issued as a longword read (`out_long` = 1), and an external halfword load as a halfword access (`out_long` = 0). Every longword access has `out_long` = 1.
- R8: With ALIGN_STORES = 0, a store uses the unmasked address (the pointer register, base plus scaled constant, or base plus index), while loads stay aligned as in R2 to R4. With ALIGN_STORES = 1, stores are aligned like loads.
- R9: `out_valid` on each clock edge equals `req_valid` sampled at that edge. While `req_valid` is 0, every other output holds its previous value.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = halfword, 0 = longword (pointer mode only) |
| req_mode | input | 2 | 0 pointer, 1 base+constant, 2 base+index, 3 as pointer |
| req_base_sel | input | 1 | 0 selects R14, 1 selects R15 |
| req_imm | input | IMM_W (5) | Constant field, 0 means 32 |
| req_index | input | AW (32) | Pointer or index register value |
| req_r14 | input | AW (32) | Base register R14 |
| req_r15 | input | AW (32) | Base register R15 |
| req_wdata | input | DW (32) | Store source data |
| out_valid | output | 1 | Registered request valid |
| out_store | output | 1 | Registered direction |
| out_word | output | 1 | Effective size is halfword |
| out_local | output | 1 | Address is in local memory |
| out_long | output | 1 | Access issued as a longword |
| out_addr | output | AW (32) | Effective address |
| out_wdata | output | DW (32) | Shaped store data |

## Verification
Base alignment and the zero-means-32 constant decode both feed the addition that decides whether a base-plus-constant access stays local. The bench places base registers with dirty low bits just below the top of the local window and uses a constant field of 0. The masked sum then lands on the last longword inside the window, or on the first address past it, depending on the base. Every such request is judged against an arithmetic model for both the address and the region flag. This is done on a masked instance and an unmasked instance side by side, so a store whose raw address differs from its aligned one is still classified from the address actually driven.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  // Addressing form carried in req_mode; code 3 is decoded as pointer mode.
  typedef enum logic [1:0] {
    AM_POINTER  = 2'd0,
    AM_BASE_IMM = 2'd1,
    AM_BASE_IDX = 2'd2,
    AM_RESERVED = 2'd3
  } amode_e;

  localparam int unsigned LONG_ALIGN_BITS = 2;

endpackage

// File: rtl/lsag_offset.sv
module lsag_offset #(
  parameter int unsigned IMM_W = 5,
  localparam int unsigned OFF_W = IMM_W + 3
) (
  input  logic [IMM_W-1:0] imm,
  output logic [OFF_W-1:0] offset
);

  logic [IMM_W:0] longwords;

  // A zero field stands for the full count 2**IMM_W.
  always_comb begin
    if (imm == '0) begin
      longwords = {1'b1, {IMM_W{1'b0}}};
    end else begin
      longwords = {1'b0, imm};
    end
    offset = {longwords, 2'b00};
  end

endmodule

// File: rtl/lsag_agen.sv
module lsag_agen
  import lsag_pkg::*;
#(
  parameter int unsigned AW           = 32,
  parameter int unsigned OFF_W        = 8,
  parameter bit          ALIGN_STORES = 1'b1
) (
  input  amode_e          mode,
  input  logic            word,
  input  logic            store,
  input  logic            base_sel,
  input  logic [AW-1:0]   index,
  input  logic [AW-1:0]   r14,
  input  logic [AW-1:0]   r15,
  input  logic [OFF_W-1:0] offset,
  output logic [AW-1:0]   addr,
  output logic            word_eff
);

  logic [AW-1:0] base;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] sum_imm_masked;
  logic [AW-1:0] sum_imm_raw;
  logic [AW-1:0] sum_idx;
  logic [AW-1:0] aligned;
  logic [AW-1:0] raw;
  logic          use_raw;

  always_comb begin
    base           = base_sel ? r15 : r14;
    off_ext        = {{(AW-OFF_W){1'b0}}, offset};
    sum_imm_masked = {base[AW-1:LONG_ALIGN_BITS], {LONG_ALIGN_BITS{1'b0}}} + off_ext;
    sum_imm_raw    = base + off_ext;
    sum_idx        = base + index;
  end

  always_comb begin
    case (mode)
      AM_BASE_IMM: begin
        word_eff = 1'b0;
        aligned  = sum_imm_masked;
        raw      = sum_imm_raw;
      end
      AM_BASE_IDX: begin
        word_eff = 1'b0;
        aligned  = {sum_idx[AW-1:LONG_ALIGN_BITS], {LONG_ALIGN_BITS{1'b0}}};
        raw      = sum_idx;
      end
      default: begin
        word_eff = word;
        if (word) begin
          aligned = {index[AW-1:1], 1'b0};
        end else begin
          aligned = {index[AW-1:LONG_ALIGN_BITS], {LONG_ALIGN_BITS{1'b0}}};
        end
        raw = index;
      end
    endcase
  end

  always_comb begin
    use_raw = store && !ALIGN_STORES;
    addr    = use_raw ? raw : aligned;
  end

endmodule

// File: rtl/lsag_region.sv
module lsag_region #(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  LOCAL_BASE = 32'h00F1_B000,
  parameter int unsigned    SPAN_LOG2  = 13
) (
  input  logic [AW-1:0] addr,
  output logic          is_local
);

  localparam logic [AW-1:0] SPAN_M1    = AW'((64'd1 << SPAN_LOG2) - 64'd1);
  localparam logic [AW-1:0] LOCAL_LAST = LOCAL_BASE + SPAN_M1;

  always_comb begin
    is_local = (addr >= LOCAL_BASE) && (addr <= LOCAL_LAST);
  end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsag_pkg::*;
#(
  parameter int unsigned   AW           = 32,
  parameter int unsigned   DW           = 32,
  parameter int unsigned   HALF_W       = 16,
  parameter int unsigned   IMM_W        = 5,
  parameter int unsigned   SPAN_LOG2    = 13,
  parameter logic [AW-1:0] LOCAL_BASE   = 32'h00F1_B000,
  parameter bit            ALIGN_STORES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_word,
  input  logic [1:0]       req_mode,
  input  logic             req_base_sel,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [AW-1:0]    req_index,
  input  logic [AW-1:0]    req_r14,
  input  logic [AW-1:0]    req_r15,
  input  logic [DW-1:0]    req_wdata,
  output logic             out_valid,
  output logic             out_store,
  output logic             out_word,
  output logic             out_local,
  output logic             out_long,
  output logic [AW-1:0]    out_addr,
  output logic [DW-1:0]    out_wdata
);

  localparam int unsigned OFF_W = IMM_W + 3;

  logic [OFF_W-1:0] offset;
  logic [AW-1:0]    addr_c;
  logic             word_c;
  logic             local_c;
  amode_e           mode_c;

  logic             valid_d, store_d, word_d, local_d, long_d;
  logic [AW-1:0]    addr_d;
  logic [DW-1:0]    wdata_d;

  assign mode_c = amode_e'(req_mode);

  lsag_offset #(.IMM_W(IMM_W)) u_offset (
    .imm    (req_imm),
    .offset (offset)
  );

  lsag_agen #(.AW(AW), .OFF_W(OFF_W), .ALIGN_STORES(ALIGN_STORES)) u_agen (
    .mode     (mode_c),
    .word     (req_word),
    .store    (req_store),
    .base_sel (req_base_sel),
    .index    (req_index),
    .r14      (req_r14),
    .r15      (req_r15),
    .offset   (offset),
    .addr     (addr_c),
    .word_eff (word_c)
  );

  lsag_region #(.AW(AW), .LOCAL_BASE(LOCAL_BASE), .SPAN_LOG2(SPAN_LOG2)) u_region (
    .addr     (addr_c),
    .is_local (local_c)
  );

  // Next-state: hold everything but valid when no request is present.
  always_comb begin
    valid_d = req_valid;
    store_d = out_store;
    word_d  = out_word;
    local_d = out_local;
    long_d  = out_long;
    addr_d  = out_addr;
    wdata_d = out_wdata;
    if (req_valid) begin
      store_d = req_store;
      word_d  = word_c;
      local_d = local_c;
      long_d  = !word_c || local_c;
      addr_d  = addr_c;
      if (word_c && req_store) begin
        wdata_d = {{(DW-HALF_W){1'b0}}, req_wdata[HALF_W-1:0]};
      end else begin
        wdata_d = req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_store <= 1'b0;
      out_word  <= 1'b0;
      out_local <= 1'b0;
      out_long  <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
    end else begin
      out_valid <= valid_d;
      out_store <= store_d;
      out_word  <= word_d;
      out_local <= local_d;
      out_long  <= long_d;
      out_addr  <= addr_d;
      out_wdata <= wdata_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R9
  AST_IDLE_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_addr) && $stable(out_local)); // R9
  AST_LOAD_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_store && !out_word |-> out_addr[1:0] == 2'b00); // R3
  AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word && (!out_store || ALIGN_STORES) |-> !out_addr[0]); // R4
  AST_HALF_STORE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word && out_store |-> out_wdata[DW-1:HALF_W] == '0); // R6
  AST_EXT_HALF_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word && !out_local |-> !out_long); // R7
  AST_LOCAL_HALF_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word && out_local |-> out_long); // R6

endmodule

// File: tb/test_lsu_addr_gen.sv
module test_lsu_addr_gen;

  localparam logic [31:0] LBASE = 32'h00F1_B000;
  localparam logic [31:0] LLAST = 32'h00F1_CFFF;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_word, req_base_sel;
  logic [1:0]  req_mode;
  logic [4:0]  req_imm;
  logic [31:0] req_index, req_r14, req_r15, req_wdata;

  logic        a_valid, a_store, a_word, a_local, a_long;
  logic [31:0] a_addr, a_wdata;
  logic        b_valid, b_store, b_word, b_local, b_long;
  logic [31:0] b_addr, b_wdata;

  int n_cmp;
  int n_bad;
  bit done;

  lsu_addr_gen #(.ALIGN_STORES(1'b1)) i_lsu_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_word(req_word), .req_mode(req_mode), .req_base_sel(req_base_sel),
    .req_imm(req_imm), .req_index(req_index), .req_r14(req_r14), .req_r15(req_r15),
    .req_wdata(req_wdata), .out_valid(a_valid), .out_store(a_store), .out_word(a_word),
    .out_local(a_local), .out_long(a_long), .out_addr(a_addr), .out_wdata(a_wdata)
  );

  lsu_addr_gen #(.ALIGN_STORES(1'b0)) i_lsu_addr_gen_raw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_word(req_word), .req_mode(req_mode), .req_base_sel(req_base_sel),
    .req_imm(req_imm), .req_index(req_index), .req_r14(req_r14), .req_r15(req_r15),
    .req_wdata(req_wdata), .out_valid(b_valid), .out_store(b_store), .out_word(b_word),
    .out_local(b_local), .out_long(b_long), .out_addr(b_addr), .out_wdata(b_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input int mode, input bit word, input bit store,
      input bit masked, input logic [4:0] imm, input logic [31:0] idx,
      input logic [31:0] r14, input logic [31:0] r15, input bit sel);
    logic [31:0] b, off;
    b   = sel ? r15 : r14;
    off = (imm == 5'd0) ? 32'd128 : ({27'd0, imm} * 32'd4);
    if (mode == 1) begin
      if (store && !masked) return b + off;
      return (b & 32'hFFFF_FFFC) + off;
    end else if (mode == 2) begin
      if (store && !masked) return b + idx;
      return (b + idx) & 32'hFFFF_FFFC;
    end
    if (store && !masked) return idx;
    return word ? (idx & 32'hFFFF_FFFE) : (idx & 32'hFFFF_FFFC);
  endfunction

  task automatic issue(input string req, input int mode, input bit word, input bit store,
      input logic [4:0] imm, input logic [31:0] idx, input logic [31:0] r14,
      input logic [31:0] r15, input bit sel, input logic [31:0] src);
    logic [31:0] ea, eb, ew;
    bit weff, la, lb;
    @(negedge clk);
    req_valid = 1'b1; req_store = store; req_word = word; req_mode = 2'(mode);
    req_imm = imm; req_index = idx; req_r14 = r14; req_r15 = r15;
    req_base_sel = sel; req_wdata = src;
    @(negedge clk);
    req_valid = 1'b0;
    ea   = model_addr(mode, word, store, 1'b1, imm, idx, r14, r15, sel);
    eb   = model_addr(mode, word, store, 1'b0, imm, idx, r14, r15, sel);
    weff = word && (mode == 0 || mode == 3);
    la   = (ea >= LBASE) && (ea <= LLAST);
    lb   = (eb >= LBASE) && (eb <= LLAST);
    ew   = (weff && store) ? {16'h0, src[15:0]} : src;
    chk("R9", "valid", {31'd0, a_valid}, 32'd1);
    chk(req, "addr", a_addr, ea);
    chk("R8", "raw addr", b_addr, eb);
    chk("R4", "word", {31'd0, a_word}, {31'd0, weff});
    chk("R5", "local", {31'd0, a_local}, {31'd0, la});
    chk("R5", "local raw", {31'd0, b_local}, {31'd0, lb});
    chk(store ? "R6" : "R7", "long", {31'd0, a_long}, {31'd0, (!weff || la)});
    chk(store ? "R6" : "R7", "long raw", {31'd0, b_long}, {31'd0, (!weff || lb)});
    if (store) chk("R6", "wdata", a_wdata, ew);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_addr;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_word = 1'b0;
    req_mode = 2'd0; req_imm = 5'd0; req_index = '0; req_r14 = '0; req_r15 = '0;
    req_base_sel = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "valid", {31'd0, a_valid}, 32'd0);
    chk("R10", "addr", a_addr, 32'd0);
    chk("R10", "long", {31'd0, a_long}, 32'd0);
    chk("R10", "wdata", a_wdata, 32'd0);
    rst_n = 1'b1;

    // R1 R2: every constant, both bases, every base misalignment, both directions
    for (int imm = 0; imm < 32; imm++)
      for (int sel = 0; sel < 2; sel++)
        for (int lo = 0; lo < 4; lo++)
          for (int st = 0; st < 2; st++)
            issue("R1", 1, st[0], st[0], 5'(imm), 32'h1234_5677,
                  LBASE + 32'h100 + 32'(lo), 32'h0020_0000 + 32'(lo), sel[0], 32'hCAFE_0000 + 32'(imm));

    // R2 with the reserved size bit set: must still be a longword
    issue("R2", 1, 1'b1, 1'b0, 5'd3, 32'h0, LBASE + 32'h2, 32'h0, 1'b0, 32'h0);

    // R3: base plus index over misaligned combinations
    for (int sel = 0; sel < 2; sel++)
      for (int lo = 0; lo < 4; lo++)
        for (int ix = 0; ix < 8; ix++)
          for (int st = 0; st < 2; st++)
            issue("R3", 2, ix[0], st[0], 5'd0, 32'h0000_1FF8 + 32'(ix),
                  LBASE + 32'(lo), 32'h0100_0000 + 32'(lo), sel[0], 32'h5555_AAAA);

    // R4 R6 R7: pointer mode and reserved code, sizes, directions, both regions
    for (int md = 0; md < 4; md += 3)
      for (int lo = 0; lo < 8; lo++)
        for (int w = 0; w < 2; w++)
          for (int st = 0; st < 2; st++) begin
            issue("R4", md, w[0], st[0], 5'd7, LBASE + 32'h40 + 32'(lo), 32'h0, 32'h0, 1'b0, 32'hDEAD_BEEF);
            issue("R4", md, w[0], st[0], 5'd7, 32'h0080_0000 + 32'(lo), 32'h0, 32'h0, 1'b1, 32'hDEAD_BEEF);
          end

    // R5: window edges
    issue("R5", 0, 1'b0, 1'b0, 5'd0, LBASE - 32'd4, 0, 0, 1'b0, 0);
    issue("R5", 0, 1'b0, 1'b0, 5'd0, LBASE, 0, 0, 1'b0, 0);
    issue("R5", 0, 1'b1, 1'b0, 5'd0, LLAST, 0, 0, 1'b0, 0);
    issue("R5", 0, 1'b1, 1'b1, 5'd0, LLAST + 32'd1, 0, 0, 1'b0, 32'h1234_8765);
    issue("R5", 0, 1'b0, 1'b0, 5'd0, 32'hFFFF_FFFF, 0, 0, 1'b0, 0);
    issue("R5", 0, 1'b0, 1'b0, 5'd0, 32'h0, 0, 0, 1'b0, 0);

    // R1 R5: zero constant with dirty base just below the window top
    for (int lo = 0; lo < 4; lo++)
      for (int st = 0; st < 2; st++) begin
        issue("R1", 1, 1'b0, st[0], 5'd0, 0, LBASE + 32'h1F7C + 32'(lo), 0, 1'b0, 32'h0BAD_F00D);
        issue("R1", 1, 1'b0, st[0], 5'd0, 0, 0, LBASE + 32'h1F80 + 32'(lo), 1'b1, 32'h0BAD_F00D);
      end

    // R9: idle cycles hold results and drop valid
    issue("R9", 0, 1'b0, 1'b0, 5'd0, LBASE + 32'h20, 0, 0, 1'b0, 0);
    hold_addr = a_addr;
    @(negedge clk);
    req_index = 32'h0300_0000; req_mode = 2'd2; req_r14 = 32'h11;
    @(negedge clk);
    chk("R9", "idle valid", {31'd0, a_valid}, 32'd0);
    chk("R9", "idle addr", a_addr, hold_addr);
    chk("R9", "idle local", {31'd0, a_local}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule